// File: doc/BRIEF.md
# Address Bus Decoder with Region Wait States

This block sits between a CPU core and the memory system of a 24-bit address space. The address is an 8-bit bank and a 16-bit offset. For each access the block decides which device owns the address: work RAM, the cartridge, internal CPU registers, or a narrow 8-bit peripheral bus. It drives the matching select and stretches the access to the number of master clocks that region needs. The peripheral bus is carried by a 256-byte window. The block forwards the low offset byte onto that bus and decodes three peripheral selects from it.

The block also keeps one speed bit, which software writes. That bit moves the cartridge space in the upper half of the banks from slow to fast timing. The block maps a small low-memory window onto the start of work RAM. When no device drives a read, the block holds the last value seen on the data bus and returns it.

A single FSM sequences each access. `S_IDLE` takes a `start` pulse and goes to `S_RUN`, loading a down-counter. `S_RUN` stays in `S_RUN` while the counter is non-zero. When the counter reaches zero, `S_RUN` goes to `S_DONE`. `S_DONE` lasts one clock, asserts `done`, and then always returns to `S_IDLE`.

Top module: `mem_bus_decoder`

## Requirements
- R1: An access begins with `start` sampled in the idle state. It holds `busy` for exactly its length in clocks, and `done` is high in the last of those clocks only. The lengths are: Fast = 6, Slow = 8, XSlow = 12. An access with neither `rd` nor `wr` is an internal cycle of 6 clocks with no select.
- R2: In system banks (bank bit 6 = 0, i.e. $00-$3F and $80-$BF), offsets $0000-$1FFF assert `wram_sel` with Slow timing. Here `wram_addr` equals the offset, which mirrors the first 8 KiB of bank $7E. When `wram_sel` is low, `wram_addr` is 0.
- R3: Banks $7E and $7F assert `wram_sel` with Slow timing over all 64 KiB. Here `wram_addr` = {bank bit 0, offset}.
- R4: In system banks, offsets $2100-$21FF are Fast peripheral accesses. `pbus_addr` = offset[7:0], and `pbus_rd` or `pbus_wr` follows the access direction. The sub-selects decode as follows: $00-$3F gives `pbus_video_sel`, $40-$7F gives `pbus_audio_sel`, and $80-$83 gives `pbus_wram_sel`. Any other peripheral address raises no sub-select.
- R5: Offsets $8000-$FFFF in banks $00-$3F, and all of banks $40-$7D, assert `cart_sel` with Slow timing.
- R6: Offsets $8000-$FFFF in banks $80-$BF, and all of banks $C0-$FF, assert `cart_sel`. Their timing is Fast when the speed bit is 1 and Slow when it is 0. The speed bit resets to 0. It takes `wdata` bit 0 at the end of a write to offset $420D in a system bank. A write to that offset in any other bank leaves it unchanged.
- R7: Some system-bank regions have no owner and assert no select. Offsets $2000-$20FF, $2200-$3FFF and $4400-$5FFF are Fast. Offsets $4000-$41FF are XSlow. Offsets $4200-$43FF are Fast. Offsets $6000-$7FFF are Slow.
- R8: In the `done` clock of a read, `cpu_rdata` shows `dev_data` when `dev_valid` is high, and the held bus value otherwise. The held value resets to 0. It updates at the end of every write (to `wdata`) and of every read with `dev_valid` (to `dev_data`). Outside those updates it does not change.
- R9: A `start` while an access is in progress is ignored. The running access keeps its length and selects, and no new access follows unless `start` is seen in the idle state.
- R10: All selects, strobes and peripheral address are 0 when not `busy`. At most one of work RAM, cartridge or peripheral bus is selected. The selects are constant for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an access (accepted only when idle) |
| bank | input | 8 | Address bank |
| offset | input | 16 | Address offset within the bank |
| rd | input | 1 | Read access |
| wr | input | 1 | Write access (wins over `rd`) |
| wdata | input | 8 | Write data |
| dev_valid | input | 1 | A device is driving `dev_data` |
| dev_data | input | 8 | Data driven by the addressed device |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last clock of the access |
| wram_sel | output | 1 | Work RAM select |
| wram_addr | output | 17 | Work RAM address |
| cart_sel | output | 1 | Cartridge select |
| pbus_addr | output | 8 | Peripheral bus address |
| pbus_rd | output | 1 | Peripheral bus read strobe |
| pbus_wr | output | 1 | Peripheral bus write strobe |
| pbus_video_sel | output | 1 | Video unit select |
| pbus_audio_sel | output | 1 | Audio unit select |
| pbus_wram_sel | output | 1 | Work RAM port select on the peripheral bus |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The speed bit is the hardest state to reach from the ports. It changes only at the end of a write to one offset in one class of banks. Its effect shows only on a later cartridge access in the upper banks.

The stimulus covers the bit in several steps:
- It sets the bit, clears it again, and tries the same offset from a non-system bank.
- After each step it measures the length of upper-bank and lower-bank cartridge accesses.

A second hard case is a `start` held high through a whole access, with the address changed mid-access. That case shows that the request is ignored and that no second access starts.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam int BANK_W  = 8;
    localparam int OFF_W   = 16;
    localparam int DATA_W  = 8;
    localparam int WADDR_W = OFF_W + 1;
    localparam int PADDR_W = 8;
    localparam int PDEV_N  = 3;

    // peripheral sub-select positions
    localparam int PDEV_VIDEO = 0;
    localparam int PDEV_AUDIO = 1;
    localparam int PDEV_WRAM  = 2;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } acc_e;

    typedef enum logic [1:0] {
        SPD_FAST,
        SPD_SLOW,
        SPD_XSLOW,
        SPD_IOP
    } speed_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_WRAM,
        TGT_CART,
        TGT_PBUS,
        TGT_CPUREG
    } tgt_e;

    typedef struct packed {
        tgt_e                 tgt;
        logic [WADDR_W-1:0]   wram_addr;
        logic [PADDR_W-1:0]   pb_addr;
        logic [PDEV_N-1:0]    pb_dev;
        logic                 speed_wr;
    } dec_t;

endpackage

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
    import busdec_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    input  acc_e              kind,
    input  logic              fast_upper,
    output dec_t              dec,
    output speed_e            spd
);

    logic sys_bank;
    logic upper_half;
    logic cart_spd_fast;

    assign sys_bank      = ~bank[BANK_W-2];
    assign upper_half    = bank[BANK_W-1];
    assign cart_spd_fast = upper_half & fast_upper;

    // peripheral sub-select from the forwarded low byte
    function automatic logic [PDEV_N-1:0] pdev_decode(input logic [PADDR_W-1:0] a);
        logic [PDEV_N-1:0] r;
        r = '0;
        if (a[7:6] == 2'b00)       r[PDEV_VIDEO] = 1'b1;
        else if (a[7:6] == 2'b01)  r[PDEV_AUDIO] = 1'b1;
        else if (a[7:2] == 6'b100000) r[PDEV_WRAM] = 1'b1;
        return r;
    endfunction

    always_comb begin
        dec      = '0;
        dec.tgt  = TGT_NONE;
        spd      = SPD_FAST;
        if (kind == ACC_NONE) begin
            spd = SPD_IOP;
        end else if (sys_bank) begin
            if (offset < 16'h2000) begin
                dec.tgt       = TGT_WRAM;
                dec.wram_addr = {4'b0000, offset[12:0]};
                spd           = SPD_SLOW;
            end else if (offset[15:8] == 8'h21) begin
                dec.tgt     = TGT_PBUS;
                dec.pb_addr = offset[PADDR_W-1:0];
                dec.pb_dev  = pdev_decode(offset[PADDR_W-1:0]);
                spd         = SPD_FAST;
            end else if (offset < 16'h4000) begin
                spd = SPD_FAST;
            end else if (offset < 16'h4200) begin
                dec.tgt = TGT_CPUREG;
                spd     = SPD_XSLOW;
            end else if (offset < 16'h4400) begin
                dec.tgt      = TGT_CPUREG;
                dec.speed_wr = (kind == ACC_WRITE) && (offset == 16'h420D);
                spd          = SPD_FAST;
            end else if (offset < 16'h6000) begin
                spd = SPD_FAST;
            end else if (!offset[OFF_W-1]) begin
                spd = SPD_SLOW;
            end else begin
                dec.tgt = TGT_CART;
                spd     = cart_spd_fast ? SPD_FAST : SPD_SLOW;
            end
        end else if (!upper_half) begin
            if (bank[BANK_W-1:1] == 7'h3F) begin
                dec.tgt       = TGT_WRAM;
                dec.wram_addr = {bank[0], offset};
            end else begin
                dec.tgt = TGT_CART;
            end
            spd = SPD_SLOW;
        end else begin
            dec.tgt = TGT_CART;
            spd     = fast_upper ? SPD_FAST : SPD_SLOW;
        end
    end

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             done,
    output logic             accept
);

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_DONE
    } st_e;

    st_e              st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    st_d  = S_RUN;
                    cnt_d = len - CNT_W'(2);
                end
            end
            S_RUN: begin
                if (cnt_q == '0) st_d = S_DONE;
                else             cnt_d = cnt_q - CNT_W'(1);
            end
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        busy   = (st_q != S_IDLE);
        done   = (st_q == S_DONE);
        accept = (st_q == S_IDLE) && start;
    end

endmodule

// File: rtl/open_bus_latch.sv
module open_bus_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (upd) q <= val;
    end

endmodule

// File: rtl/mem_bus_decoder.sv
module mem_bus_decoder
    import busdec_pkg::*;
#(
    parameter int FAST_CLKS  = 6,
    parameter int SLOW_CLKS  = 8,
    parameter int XSLOW_CLKS = 12,
    parameter int IOP_CLKS   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BANK_W-1:0]  bank,
    input  logic [OFF_W-1:0]   offset,
    input  logic               rd,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               dev_valid,
    input  logic [DATA_W-1:0]  dev_data,
    output logic               busy,
    output logic               done,
    output logic               wram_sel,
    output logic [WADDR_W-1:0] wram_addr,
    output logic               cart_sel,
    output logic [PADDR_W-1:0] pbus_addr,
    output logic               pbus_rd,
    output logic               pbus_wr,
    output logic               pbus_video_sel,
    output logic               pbus_audio_sel,
    output logic               pbus_wram_sel,
    output logic [DATA_W-1:0]  cpu_rdata
);

    localparam int MAX_AB   = (FAST_CLKS > SLOW_CLKS) ? FAST_CLKS : SLOW_CLKS;
    localparam int MAX_CD   = (XSLOW_CLKS > IOP_CLKS) ? XSLOW_CLKS : IOP_CLKS;
    localparam int MAX_CLKS = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    acc_e              kind, kind_q;
    dec_t              dec, dec_q;
    speed_e            spd;
    logic              fast_q;
    logic [CNT_W-1:0]  len;
    logic              accept;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] ob_q;
    logic              ob_upd;
    logic [DATA_W-1:0] ob_val;
    logic              pb_act;

    assign kind = wr ? ACC_WRITE : (rd ? ACC_READ : ACC_NONE);

    addr_region_decoder u_dec (
        .bank       (bank),
        .offset     (offset),
        .kind       (kind),
        .fast_upper (fast_q),
        .dec        (dec),
        .spd        (spd)
    );

    always_comb begin
        unique case (spd)
            SPD_FAST:  len = CNT_W'(FAST_CLKS);
            SPD_SLOW:  len = CNT_W'(SLOW_CLKS);
            SPD_XSLOW: len = CNT_W'(XSLOW_CLKS);
            SPD_IOP:   len = CNT_W'(IOP_CLKS);
            default:   len = CNT_W'(SLOW_CLKS);
        endcase
    end

    bus_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .len    (len),
        .busy   (busy),
        .done   (done),
        .accept (accept)
    );

    // request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q   <= '0;
            kind_q  <= ACC_NONE;
            wdata_q <= '0;
        end else if (accept) begin
            dec_q   <= dec;
            kind_q  <= kind;
            wdata_q <= wdata;
        end
    end

    // speed control bit
    always_ff @(posedge clk) begin
        if (!rst_n)                    fast_q <= 1'b0;
        else if (done && dec_q.speed_wr) fast_q <= wdata_q[0];
    end

    assign ob_upd = done && ((kind_q == ACC_WRITE) || ((kind_q == ACC_READ) && dev_valid));
    assign ob_val = (kind_q == ACC_WRITE) ? wdata_q : dev_data;

    open_bus_latch #(.W(DATA_W)) u_ob (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (ob_upd),
        .val   (ob_val),
        .q     (ob_q)
    );

    assign pb_act = busy && (dec_q.tgt == TGT_PBUS);

    always_comb begin
        wram_sel       = busy && (dec_q.tgt == TGT_WRAM);
        cart_sel       = busy && (dec_q.tgt == TGT_CART);
        wram_addr      = wram_sel ? dec_q.wram_addr : '0;
        pbus_addr      = pb_act ? dec_q.pb_addr : '0;
        pbus_rd        = pb_act && (kind_q == ACC_READ);
        pbus_wr        = pb_act && (kind_q == ACC_WRITE);
        pbus_video_sel = pb_act && dec_q.pb_dev[PDEV_VIDEO];
        pbus_audio_sel = pb_act && dec_q.pb_dev[PDEV_AUDIO];
        pbus_wram_sel  = pb_act && dec_q.pb_dev[PDEV_WRAM];
        cpu_rdata      = (done && (kind_q == ACC_READ) && dev_valid) ? dev_data : ob_q;
    end

endmodule

// File: rtl/mem_bus_decoder_chk.sv
module mem_bus_decoder_chk #(
    parameter int FAST_CLKS  = 6,
    parameter int SLOW_CLKS  = 8,
    parameter int XSLOW_CLKS = 12,
    parameter int IOP_CLKS   = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        wram_sel,
    input logic [16:0] wram_addr,
    input logic        cart_sel,
    input logic [7:0]  pbus_addr,
    input logic        pbus_rd,
    input logic        pbus_wr,
    input logic        pbus_video_sel,
    input logic        pbus_audio_sel,
    input logic        pbus_wram_sel,
    input logic [7:0]  cpu_rdata
);

    int len_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            len_cnt <= 0;
        else if (busy && !done) len_cnt <= len_cnt + 1;
        else                   len_cnt <= 0;
    end

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((len_cnt + 1 == FAST_CLKS) || (len_cnt + 1 == SLOW_CLKS) ||
                  (len_cnt + 1 == XSLOW_CLKS) || (len_cnt + 1 == IOP_CLKS))); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R1

    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(wram_sel || cart_sel || pbus_rd || pbus_wr ||
                    pbus_video_sel || pbus_audio_sel || pbus_wram_sel)); // R10

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wram_sel, cart_sel, (pbus_rd | pbus_wr)})); // R10

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(wram_sel) && $stable(cart_sel) &&
                             $stable(wram_addr) && $stable(pbus_addr))); // R10

    AST_PDEV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pbus_video_sel, pbus_audio_sel, pbus_wram_sel})); // R4

    AST_PDEV_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_video_sel || pbus_audio_sel || pbus_wram_sel) |-> (pbus_rd || pbus_wr)); // R4

    AST_WADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wram_sel |-> (wram_addr == '0)); // R2

    AST_OPENBUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(done)) |-> $stable(cpu_rdata)); // R8

endmodule

bind mem_bus_decoder mem_bus_decoder_chk #(
    .FAST_CLKS  (FAST_CLKS),
    .SLOW_CLKS  (SLOW_CLKS),
    .XSLOW_CLKS (XSLOW_CLKS),
    .IOP_CLKS   (IOP_CLKS)
) u_chk (.*);

// File: tb/tb_mem_bus_decoder.sv
module tb_mem_bus_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  bank;
    logic [15:0] offset;
    logic        rd, wr;
    logic [7:0]  wdata;
    logic        dev_valid;
    logic [7:0]  dev_data;
    logic        busy, done;
    logic        wram_sel, cart_sel;
    logic [16:0] wram_addr;
    logic [7:0]  pbus_addr;
    logic        pbus_rd, pbus_wr;
    logic        pbus_video_sel, pbus_audio_sel, pbus_wram_sel;
    logic [7:0]  cpu_rdata;
    logic [31:0] sel_vec;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] ob_m   = 8'h00;
    bit         fast_m = 1'b0;

    always #4ns clk = ~clk;   // 125 MHz

    mem_bus_decoder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bank(bank), .offset(offset),
        .rd(rd), .wr(wr), .wdata(wdata), .dev_valid(dev_valid), .dev_data(dev_data),
        .busy(busy), .done(done), .wram_sel(wram_sel), .wram_addr(wram_addr),
        .cart_sel(cart_sel), .pbus_addr(pbus_addr), .pbus_rd(pbus_rd), .pbus_wr(pbus_wr),
        .pbus_video_sel(pbus_video_sel), .pbus_audio_sel(pbus_audio_sel),
        .pbus_wram_sel(pbus_wram_sel), .cpu_rdata(cpu_rdata)
    );

    assign sel_vec = {wram_sel, cart_sel, pbus_rd, pbus_wr, pbus_video_sel,
                      pbus_audio_sel, pbus_wram_sel, pbus_addr, wram_addr};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural address map: kd 0 = internal, 1 = read, 2 = write
    task automatic predict(input int bk, input int of, input int kd,
                           output int len, output logic [31:0] ev, output bit pend);
        bit ws = 0, cs = 0, pb = 0, pv = 0, pa = 0, pw = 0;
        int wa = 0, lo = of & 255;
        pend = 0;
        len  = 8;
        if (kd == 0) begin
            len = 6;
        end else if ((bk & 'h40) == 0) begin
            if (of < 'h2000) begin ws = 1; wa = of; len = 8; end
            else if (of >= 'h2100 && of < 'h2200) begin
                pb = 1; len = 6;
                pv = (lo < 64); pa = (lo >= 64 && lo < 128); pw = (lo >= 128 && lo <= 131);
            end
            else if (of < 'h4000) len = 6;
            else if (of < 'h4200) len = 12;
            else if (of < 'h4400) begin len = 6; pend = (kd == 2 && of == 'h420D); end
            else if (of < 'h6000) len = 6;
            else if (of < 'h8000) len = 8;
            else begin cs = 1; len = (bk >= 'h80 && fast_m) ? 6 : 8; end
        end else if (bk < 'h7E) begin cs = 1; len = 8; end
        else if (bk < 'h80) begin ws = 1; wa = (bk & 1) * 65536 + of; len = 8; end
        else begin cs = 1; len = fast_m ? 6 : 8; end
        ev = {ws, cs, pb && kd == 1, pb && kd == 2, pb && pv, pb && pa, pb && pw,
              pb ? lo[7:0] : 8'h00, wa[16:0]};
    endtask

    task automatic run_access(input string req, input int bk, input int of, input int kd,
                              input int wd, input bit dv, input int dd, input bit hold);
        int len;
        int n;
        logic [31:0] ev;
        bit pend;
        logic [7:0] er;
        predict(bk, of, kd, len, ev, pend);
        er = (kd == 1 && dv) ? dd[7:0] : ob_m;
        @(negedge clk);
        chk("R10", sel_vec, 32'h0, "selects while idle");
        bank = bk[7:0]; offset = of[15:0]; rd = (kd == 1); wr = (kd == 2);
        wdata = wd[7:0]; dev_valid = dv; dev_data = dd[7:0]; start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        else begin bank = 8'hC0; offset = 16'h0000; rd = 1'b0; wr = 1'b1; end
        n = 0;
        while (busy && n < 64) begin
            n++;
            chk(req, sel_vec, ev, "selects during access");
            chk("R1", {31'b0, done}, {31'b0, (n == len)}, "done position");
            if (done) begin
                chk("R8", {24'b0, cpu_rdata}, {24'b0, er}, "read data at done");
                start = 1'b0;
            end
            @(negedge clk);
        end
        chk(hold ? "R9" : "R1", n, len, "access length");
        if (hold) chk("R9", {31'b0, busy}, 32'h0, "no access after ignored start");
        if (kd == 2) ob_m = wd[7:0];
        else if (kd == 1 && dv) ob_m = dd[7:0];
        if (pend) fast_m = wd[0];
        rd = 1'b0; wr = 1'b0; dev_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; bank = '0; offset = '0; rd = 1'b0; wr = 1'b0;
        wdata = '0; dev_valid = 1'b0; dev_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", {sel_vec[31:1], busy}, 32'h0, "reset selects and busy");
        chk("R1", {31'b0, done}, 32'h0, "reset done");
        chk("R8", {24'b0, cpu_rdata}, 32'h0, "reset open bus");

        // R2 low-memory mirror of work RAM
        run_access("R2", 'h00, 'h0123, 1, 0, 1, 'h5A, 0);
        run_access("R2", 'h80, 'h1FFF, 2, 'h3C, 0, 0, 0);
        run_access("R2", 'h3F, 'h0000, 1, 0, 0, 0, 0);
        // R3 full work RAM banks
        run_access("R3", 'h7E, 'h0123, 1, 0, 1, 'h11, 0);
        run_access("R3", 'h7F, 'hFFFF, 2, 'h22, 0, 0, 0);
        // R4 peripheral window
        run_access("R4", 'h00, 'h2118, 2, 'h77, 0, 0, 0);
        run_access("R4", 'h00, 'h2140, 1, 0, 1, 'h99, 0);
        run_access("R4", 'h80, 'h2181, 1, 0, 1, 'hA5, 0);
        run_access("R4", 'h00, 'h2190, 2, 'h01, 0, 0, 0);
        run_access("R4", 'hBF, 'h21FF, 1, 0, 0, 0, 0);
        // R5 cartridge, slow half
        run_access("R5", 'h00, 'h8000, 1, 0, 1, 'h42, 0);
        run_access("R5", 'h40, 'h1234, 1, 0, 1, 'h43, 0);
        run_access("R5", 'h7D, 'hFFFF, 2, 'h44, 0, 0, 0);
        // R6 upper half slow after reset
        run_access("R6", 'h80, 'h8000, 1, 0, 0, 0, 0);
        run_access("R6", 'hC0, 'h0000, 1, 0, 0, 0, 0);
        // R7 regions with no owner
        run_access("R7", 'h00, 'h2000, 1, 0, 0, 0, 0);
        run_access("R7", 'h00, 'h3FFF, 2, 'h55, 0, 0, 0);
        run_access("R7", 'h00, 'h4016, 1, 0, 0, 0, 0);
        run_access("R7", 'h80, 'h4200, 1, 0, 0, 0, 0);
        run_access("R7", 'h00, 'h5000, 2, 'h66, 0, 0, 0);
        run_access("R7", 'h00, 'h6000, 1, 0, 0, 0, 0);
        // R1 internal cycle
        run_access("R1", 'h00, 'h8000, 0, 0, 0, 0, 0);
        // R6 speed bit set, then effects
        run_access("R6", 'h00, 'h420D, 2, 'h01, 0, 0, 0);
        run_access("R6", 'h80, 'h8000, 1, 0, 1, 'h12, 0);
        run_access("R6", 'hFF, 'hFFFF, 1, 0, 0, 0, 0);
        run_access("R6", 'h00, 'h8000, 1, 0, 0, 0, 0);
        run_access("R6", 'h40, 'h0000, 1, 0, 0, 0, 0);
        // R6 write at same offset in non-system bank has no effect
        run_access("R6", 'h40, 'h420D, 2, 'h00, 0, 0, 0);
        run_access("R6", 'hC0, 'h0000, 1, 0, 0, 0, 0);
        // R6 clear the bit again
        run_access("R6", 'h80, 'h420D, 2, 'hFE, 0, 0, 0);
        run_access("R6", 'hC0, 'h0000, 1, 0, 0, 0, 0);
        // R8 open bus after a write, then a driven read
        run_access("R8", 'h00, 'h5000, 2, 'hC3, 0, 0, 0);
        run_access("R8", 'h00, 'h6000, 1, 0, 0, 0, 0);
        run_access("R8", 'h7E, 'h0010, 1, 0, 1, 'h3E, 0);
        run_access("R8", 'h00, 'h4016, 1, 0, 0, 0, 0);
        run_access("R8", 'h00, 'h4016, 0, 0, 1, 'hEE, 0);
        run_access("R8", 'h00, 'h6001, 1, 0, 0, 0, 0);
        // R9 start held through an access with a changed address
        run_access("R9", 'h00, 'h0100, 1, 0, 1, 'h81, 1);
        run_access("R9", 'h00, 'h4100, 2, 'h18, 0, 0, 1);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule